// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block moves one 8-bit PCM sample in each direction per 8 kHz frame on a serial PCM highway. In the transmit direction it shifts a parallel byte out on one of two data lines during a chosen bit window. For that same window it pulls the matching active-low strobe, which is meant to enable an external backplane line driver. In the receive direction it captures eight bits from one of two data lines during a chosen window. It then presents the byte together with a one-cycle valid pulse.

Each direction has its own frame sync and its own configuration. In immediate mode the frame sync marks the start of the device's own slot. In counted mode the frame sync marks the start of the frame, and an internal bit counter locates slot N among up to `SLOTS` 8-bit slots. The highway bit clock, both frame syncs and the receive lines are sampled by the fast system clock through a two-stage synchronizer. All highway events are therefore seen a fixed number of system cycles after they occur. Each transmit line is presented as a data bit plus an output enable, ready for a pad tristate cell.

Top module: `pcm_tdm_port`

## Requirements
- R1: While reset is held, and after it is released but before any frame sync, every `txd_oe` bit is 0, every `txd` bit is 0, every `tx_strobe_n` bit is 1, `rx_valid` is 0 and `rx_byte` is 0.
- R2: In immediate mode (`tx_delayed`=0), the transmit slot covers the 8 bit periods that start with the bit-clock rising edge on which `tx_sync` rises. The byte is sent most significant bit first, one bit per period, and each bit changes after a rising edge of `bit_clk`.
- R3: In counted mode (`tx_delayed`=1 or `rx_delayed`=1), period 0 of the frame starts at the rising bit-clock edge that coincides with the sync rise, and slot N occupies periods 8N through 8N+7.
- R4: A port value p routes the transmit byte to `txd[p]`/`txd_oe[p]` and pulls only `tx_strobe_n[p]` low. It routes reception from `rxd[p]`. At most one strobe is low at any time.
- R5: Outside the active transmit slot, all `txd_oe` bits are 0, all `txd` bits are 0 and all strobes are 1.
- R6: During the active receive slot, `rxd[rx_port]` is sampled on falling edges of `bit_clk`, most significant bit first. After the eighth sample, `rx_byte` holds the byte and `rx_valid` is high for exactly one system clock cycle.
- R7: Bits on the unselected receive line, and bits on the selected line outside the receive slot, have no effect on `rx_byte`.
- R8: With `tx_en`=0 no transmit enable or strobe is asserted. With `rx_en`=0 no `rx_valid` pulse occurs and `rx_byte` keeps its value.
- R9: Slot N (or the single slot in immediate mode, N=0) becomes active only if 8N+8 does not exceed the length, in bit periods, of the previous frame. That length is the number of periods between the two most recent syncs. Until a second sync has been seen after reset, the length is taken as 8*SLOTS.
- R10: A sync that arrives while a slot is in progress ends that slot at once and restarts period counting. The aborted receive slot produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Highway bit clock |
| tx_sync | input | 1 | Transmit frame sync (pulse or square wave) |
| rx_sync | input | 1 | Receive frame sync (pulse or square wave) |
| rxd | input | NPORTS | Receive data lines |
| tx_byte | input | 8 | Byte to send, taken at the first bit of the slot |
| tx_en | input | 1 | Transmit direction enable |
| tx_delayed | input | 1 | Transmit counted mode (1) or immediate mode (0) |
| tx_slot | input | log2(SLOTS) | Transmit slot number in counted mode |
| tx_port | input | log2(NPORTS) | Transmit port select |
| rx_en | input | 1 | Receive direction enable |
| rx_delayed | input | 1 | Receive counted mode (1) or immediate mode (0) |
| rx_slot | input | log2(SLOTS) | Receive slot number in counted mode |
| rx_port | input | log2(NPORTS) | Receive port select |
| txd | output | NPORTS | Transmit data, 0 when not driven |
| txd_oe | output | NPORTS | Transmit output enable per line |
| tx_strobe_n | output | NPORTS | Active-low slot strobe per line (open-drain model, 1 = released) |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is updated |

## Verification
The checker assumes that the enable, mode, slot and port fields change only while neither direction has a slot in progress. Under that assumption, a strobe can change only after a synchronized bit-clock rise, and a strobe being low implies that the transmit port matches and transmission is enabled. The stimulus respects this by changing configuration only after two idle bit periods that follow each group of frames. It also holds every highway input constant for eight system cycles around each bit-clock edge, so both syncs and the data lines pass the synchronizer in the same cycle as the bit-clock edge they accompany.

// File: rtl/pcm_tdm_pkg.sv
package pcm_tdm_pkg;
   localparam int unsigned SLOT_BITS = 8;
   localparam int unsigned IDX_W     = $clog2(SLOT_BITS);

   typedef logic [SLOT_BITS-1:0] pcm_byte_t;
   typedef logic [IDX_W-1:0]     bit_idx_t;

   // registered slot position: slot active and bit index inside the slot
   typedef struct packed {
      logic     act;
      bit_idx_t idx;
   } slot_pos_t;
endpackage

// File: rtl/pcm_sync.sv
module pcm_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_sync needs at least two stages");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
   import pcm_tdm_pkg::*;
#(
   parameter  int unsigned SLOTS  = 64,
   localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_rise,
   input  logic              sync_rise,
   input  logic              en,
   input  logic              delayed,
   input  logic [SLOT_W-1:0] slot,
   output slot_pos_t         pos_o,
   output logic              load_o
);
   localparam int unsigned FRAME_MAX = SLOTS * SLOT_BITS;
   localparam int unsigned POS_W     = $clog2(FRAME_MAX) + 1;
   localparam logic [POS_W-1:0] POS_SAT = '1;

   logic             run_q, pend_q, go, run_d, act_d;
   logic [POS_W-1:0] pos_q, pos_d, flen_q, flen_d, start, stop;

   always_comb begin
      go     = bit_rise & (pend_q | sync_rise);
      run_d  = run_q | go;
      pos_d  = go ? '0 : ((pos_q == POS_SAT) ? pos_q : pos_q + POS_W'(1));
      flen_d = (go && run_q) ? pos_q + POS_W'(1) : flen_q;
      start  = delayed ? (POS_W'(slot) << IDX_W) : '0;
      stop   = start + POS_W'(SLOT_BITS);
      act_d  = en & run_d & (stop <= flen_d) & (pos_d >= start) & (pos_d < stop);
   end

   assign load_o = bit_rise & act_d & (pos_d == start);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
         pos_q  <= '0;
         flen_q <= POS_W'(FRAME_MAX);
         pos_o  <= '0;
      end else begin
         if (bit_rise)       pend_q <= 1'b0;
         else if (sync_rise) pend_q <= 1'b1;
         if (bit_rise) begin
            run_q     <= run_d;
            pos_q     <= pos_d;
            flen_q    <= flen_d;
            pos_o.act <= act_d;
            pos_o.idx <= IDX_W'(pos_d - start);
         end
      end
   end
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
   import pcm_tdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  pcm_byte_t tx_byte,
   input  bit_idx_t  idx,
   output logic      dbit
);
   pcm_byte_t hold_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    hold_q <= '0;
      else if (load) hold_q <= tx_byte;
   end

   // most significant bit leaves first
   assign dbit = hold_q[bit_idx_t'(SLOT_BITS-1) - idx];
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift
   import pcm_tdm_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clear,
   input  logic      sample,
   input  logic      din,
   input  bit_idx_t  idx,
   output pcm_byte_t byte_o,
   output logic      valid_o
);
   pcm_byte_t sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '0;
         byte_o  <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (clear) sh_q <= '0;
         if (sample) begin
            sh_q <= {sh_q[SLOT_BITS-2:0], din};
            if (idx == '1) begin
               byte_o  <= {sh_q[SLOT_BITS-2:0], din};
               valid_o <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_tdm_port.sv
module pcm_tdm_port
   import pcm_tdm_pkg::*;
#(
   parameter  int unsigned SLOTS  = 64,
   parameter  int unsigned NPORTS = 2,
   localparam int unsigned SLOT_W = $clog2(SLOTS),
   localparam int unsigned PSEL_W = $clog2(NPORTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk,
   input  logic              tx_sync,
   input  logic              rx_sync,
   input  logic [NPORTS-1:0] rxd,
   input  logic [7:0]        tx_byte,
   input  logic              tx_en,
   input  logic              tx_delayed,
   input  logic [SLOT_W-1:0] tx_slot,
   input  logic [PSEL_W-1:0] tx_port,
   input  logic              rx_en,
   input  logic              rx_delayed,
   input  logic [SLOT_W-1:0] rx_slot,
   input  logic [PSEL_W-1:0] rx_port,
   output logic [NPORTS-1:0] txd,
   output logic [NPORTS-1:0] txd_oe,
   output logic [NPORTS-1:0] tx_strobe_n,
   output logic [7:0]        rx_byte,
   output logic              rx_valid
);
   localparam int unsigned SYNC_W = 3 + NPORTS;

   if (SLOTS < 2 || SLOTS > 64 || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
      $error("SLOTS must be a power of two from 2 to 64");
   end
   if (NPORTS < 2 || (1 << PSEL_W) != NPORTS) begin : g_bad_ports
      $error("NPORTS must be a power of two of at least 2");
   end
   if (SLOT_BITS != 8) begin : g_bad_width
      $error("slot width must match the 8-bit byte ports");
   end

   logic [SYNC_W-1:0] sync_q;
   logic [2:0]        edge_q;
   logic              bclk_rise, bclk_fall, txs_rise, rxs_rise, tx_bit;
   logic [NPORTS-1:0] rxd_s;
   slot_pos_t         tx_pos, rx_pos;
   logic              tx_load, rx_load;

   pcm_sync #(.W(SYNC_W), .STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({rxd, rx_sync, tx_sync, bit_clk}), .q(sync_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) edge_q <= '0;
      else        edge_q <= sync_q[2:0];
   end

   assign bclk_rise = sync_q[0] & ~edge_q[0];
   assign bclk_fall = ~sync_q[0] & edge_q[0];
   assign txs_rise  = sync_q[1] & ~edge_q[1];
   assign rxs_rise  = sync_q[2] & ~edge_q[2];
   assign rxd_s     = sync_q[SYNC_W-1:3];

   pcm_slot_timer #(.SLOTS(SLOTS)) u_tx_timer (
      .clk(clk), .rst_n(rst_n), .bit_rise(bclk_rise), .sync_rise(txs_rise),
      .en(tx_en), .delayed(tx_delayed), .slot(tx_slot),
      .pos_o(tx_pos), .load_o(tx_load)
   );

   pcm_slot_timer #(.SLOTS(SLOTS)) u_rx_timer (
      .clk(clk), .rst_n(rst_n), .bit_rise(bclk_rise), .sync_rise(rxs_rise),
      .en(rx_en), .delayed(rx_delayed), .slot(rx_slot),
      .pos_o(rx_pos), .load_o(rx_load)
   );

   pcm_tx_shift u_tx_shift (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .tx_byte(tx_byte),
      .idx(tx_pos.idx), .dbit(tx_bit)
   );

   pcm_rx_shift u_rx_shift (
      .clk(clk), .rst_n(rst_n), .clear(rx_load),
      .sample(bclk_fall & rx_pos.act), .din(rxd_s[rx_port]),
      .idx(rx_pos.idx), .byte_o(rx_byte), .valid_o(rx_valid)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic sel;
      assign sel            = tx_pos.act && (tx_port == PSEL_W'(p));
      assign txd_oe[p]      = sel;
      assign txd[p]         = sel & tx_bit;
      assign tx_strobe_n[p] = ~sel;
   end
endmodule

// File: rtl/pcm_tdm_port_chk.sv
module pcm_tdm_port_chk #(
   parameter int unsigned NPORTS = 2,
   parameter int unsigned PSEL_W = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NPORTS-1:0] tx_strobe_n,
   input logic              tx_en,
   input logic [PSEL_W-1:0] tx_port,
   input logic              rx_en,
   input logic              rx_valid,
   input logic              bclk_rise,
   input logic              bclk_fall
);
   assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~tx_strobe_n));

   assert_strobe_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (~tx_strobe_n != '0) |-> tx_en);

   assert_strobe_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_strobe_n) |-> $past(bclk_rise));

   assert_valid_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   assert_valid_after_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bclk_fall));

   assert_valid_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_en);

   for (genvar p = 0; p < NPORTS; p++) begin : g_chk
      assert_strobe_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
         !tx_strobe_n[p] |-> (tx_port == PSEL_W'(p)));
   end
endmodule

bind pcm_tdm_port pcm_tdm_port_chk #(.NPORTS(NPORTS), .PSEL_W(PSEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_strobe_n(tx_strobe_n), .tx_en(tx_en),
   .tx_port(tx_port), .rx_en(rx_en), .rx_valid(rx_valid),
   .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
);

// File: tb/pcm_tdm_port_test.sv
module pcm_tdm_port_test;
   localparam int SLOTS = 64;
   localparam int HALF  = 8;
   localparam int NVEC  = 7;

   logic clk = 1'b0, rst_n = 1'b0, bit_clk = 1'b0, tx_sync = 1'b0, rx_sync = 1'b0;
   logic [1:0] rxd = '0;
   logic [7:0] tx_byte = '0;
   logic tx_en = 0, tx_delayed = 0, rx_en = 0, rx_delayed = 0;
   logic [5:0] tx_slot = '0, rx_slot = '0;
   logic [0:0] tx_port = '0, rx_port = '0;
   logic [1:0] txd, txd_oe, tx_strobe_n;
   logic [7:0] rx_byte;
   logic       rx_valid;

   always #5 clk = ~clk;

   pcm_tdm_port #(.SLOTS(SLOTS), .NPORTS(2)) uut (
      .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .tx_sync(tx_sync), .rx_sync(rx_sync),
      .rxd(rxd), .tx_byte(tx_byte), .tx_en(tx_en), .tx_delayed(tx_delayed),
      .tx_slot(tx_slot), .tx_port(tx_port), .rx_en(rx_en), .rx_delayed(rx_delayed),
      .rx_slot(rx_slot), .rx_port(rx_port), .txd(txd), .txd_oe(txd_oe),
      .tx_strobe_n(tx_strobe_n), .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   // {dly, tx_en, tx_slot, tx_port, tx_byte, rx_en, rx_slot, rx_port, rx_byte, nbits}
   localparam logic [42:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 6'd0, 1'b0, 8'hA5, 1'b1, 6'd0, 1'b0, 8'h3C, 10'd16},
      {1'b0, 1'b1, 6'd0, 1'b1, 8'h81, 1'b1, 6'd0, 1'b1, 8'hC3, 10'd24},
      {1'b1, 1'b1, 6'd2, 1'b0, 8'h5A, 1'b1, 6'd1, 1'b1, 8'h96, 10'd32},
      {1'b1, 1'b1, 6'd3, 1'b1, 8'hF0, 1'b1, 6'd3, 1'b0, 8'h0F, 10'd32},
      {1'b1, 1'b1, 6'd4, 1'b0, 8'h77, 1'b1, 6'd5, 1'b1, 8'hE1, 10'd32},
      {1'b0, 1'b0, 6'd0, 1'b1, 8'hFF, 1'b0, 6'd0, 1'b0, 8'h55, 10'd16},
      {1'b1, 1'b1, 6'd7, 1'b1, 8'h3C, 1'b1, 6'd0, 1'b0, 8'hB4, 10'd64}
   };
   string TAGS [NVEC] = '{"R2", "R4", "R3", "R9", "R9", "R8", "R3"};

   int n_chk = 0, n_bad = 0;
   int vcnt = 0, exp_cnt = 0;
   logic [7:0] vbyte = '0, exp_byte = '0, rx_src = '0;
   int pos = -1, flen = SLOTS * 8;
   logic [7:0] lfsr = 8'h5B;
   string cur_tag = "R2";

   always @(negedge clk) if (rst_n && rx_valid) begin
      vcnt  = vcnt + 1;
      vbyte = rx_byte;
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit in_slot(input bit en, input bit dly, input int slot);
      int st;
      st = dly ? slot * 8 : 0;
      return en && pos >= 0 && st + 8 <= flen && pos >= st && pos < st + 8;
   endfunction

   task automatic bit_period(input bit fs);
      bit txa, rxa;
      int txs, rxs;
      logic [1:0] e_oe, e_d, e_st;
      if (fs) begin
         if (pos >= 0) flen = pos + 1;
         pos = 0;
      end else if (pos >= 0 && pos < 1023) pos++;
      txa = in_slot(tx_en, tx_delayed, int'(tx_slot));
      rxa = in_slot(rx_en, rx_delayed, int'(rx_slot));
      txs = tx_delayed ? int'(tx_slot) * 8 : 0;
      rxs = rx_delayed ? int'(rx_slot) * 8 : 0;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rxd = lfsr[1:0];
      if (rxa) rxd[rx_port] = rx_src[7 - (pos - rxs)];
      bit_clk = 1'b1; tx_sync = fs; rx_sync = fs;
      repeat (HALF - 1) @(negedge clk);
      e_oe = '0; e_d = '0; e_st = 2'b11;
      if (txa) begin
         e_oe[tx_port] = 1'b1;
         e_d[tx_port]  = tx_byte[7 - (pos - txs)];
         e_st[tx_port] = 1'b0;
      end
      check({txd_oe, txd, tx_strobe_n} === {e_oe, e_d, e_st},
            txa ? cur_tag : "R5", $sformatf("tx lines at period %0d", pos),
            32'({txd_oe, txd, tx_strobe_n}), 32'({e_oe, e_d, e_st}));
      @(negedge clk);
      bit_clk = 1'b0;
      if (rxa && pos == rxs + 7) begin
         exp_cnt++;
         exp_byte = rx_src;
      end
      repeat (HALF) @(negedge clk);
   endtask

   task automatic run_frame(input int n);
      bit_period(1'b1);
      for (int i = 1; i < n; i++) bit_period(1'b0);
   endtask

   task automatic check_rx(input string tag);
      check(vcnt == exp_cnt, tag, "rx valid count (R6)", 32'(vcnt), 32'(exp_cnt));
      check(rx_byte == exp_byte, tag, "rx byte (R7)", 32'(rx_byte), 32'(exp_byte));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: outputs during reset
      check({txd_oe, txd, tx_strobe_n, rx_valid, rx_byte} == {6'b000011, 1'b0, 8'h00},
            "R1", "reset outputs", 32'({txd_oe, txd, tx_strobe_n, rx_valid, rx_byte}),
            32'({6'b000011, 9'h000}));
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R1: after release, before any sync, while the bit clock runs
      tx_en = 1'b1; rx_en = 1'b1;
      bit_period(1'b0);
      check(vcnt == 0 && rx_byte == 8'h00, "R1", "rx idle before sync",
            32'({vcnt[7:0], rx_byte}), 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         tx_delayed = VEC[i][42]; rx_delayed = VEC[i][42];
         tx_en   = VEC[i][41];    tx_slot = VEC[i][40:35];
         tx_port = VEC[i][34];    tx_byte = VEC[i][33:26];
         rx_en   = VEC[i][25];    rx_slot = VEC[i][24:19];
         rx_port = VEC[i][18];    rx_src  = VEC[i][17:10];
         cur_tag = TAGS[i];
         run_frame(int'(VEC[i][9:0]));
         run_frame(int'(VEC[i][9:0]));
         bit_period(1'b0); bit_period(1'b0);
         check_rx(TAGS[i]);
      end

      // R10: a sync in the middle of slot 1 aborts it and restarts counting
      cur_tag = "R10";
      tx_delayed = 1; rx_delayed = 1; tx_en = 1; rx_en = 1;
      tx_slot = 6'd1; rx_slot = 6'd1; tx_port = 0; rx_port = 1;
      tx_byte = 8'hC6; rx_src = 8'h6C;
      run_frame(40);
      run_frame(12);
      run_frame(40);
      run_frame(32);
      bit_period(1'b0); bit_period(1'b0);
      check_rx("R10");

      // R8: disabled receive leaves rx_byte untouched with other data on the line
      rx_en = 0; rx_src = 8'h00;
      run_frame(32); run_frame(32);
      bit_period(1'b0); bit_period(1'b0);
      check(rx_byte == exp_byte && vcnt == exp_cnt, "R8", "rx held while disabled",
            32'({vcnt[7:0], rx_byte}), 32'({exp_cnt[7:0], exp_byte}));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule